// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-cycle-access burst SRAM. Words are split into byte lanes, each 8 data bits plus 1 parity bit, and each lane has its own write strobe. An access starts on a clock edge where one of two address strobes is low. The first is the processor strobe, which the master chip enable gates. The second is the controller strobe, which is accepted only when the processor strobe is not in effect. Once started, a burst walks the two low address bits in linear or interleaved order while the advance input is held low. Reads are flow-through: the word at the registered address drives the read port combinationally in the cycle after the address edge.

Write precedence has two layers. A global write enable writes every lane. Otherwise a byte-write enable combined with per-lane strobes writes the selected lanes. Any other combination is a read. The bidirectional data bus is split into a write-data input, a read-data output and an output-enable output. An asynchronous output enable and an asynchronous sleep input gate that output enable directly.

Top module: `flowthru_burst_sram`

## Requirements
- R1: Lane l occupies bits [9l+8:9l] and is selected by `lane_we_ni[l]`. On a write-sampling edge, `gw_ni`=0 writes every lane. With `gw_ni`=1 and `bw_en_ni`=0, each lane whose strobe is 0 is written and the other lanes keep their contents. Any other combination is a read.
- R2: The edge is a processor start when `proc_stb_ni`=0, `ce_main_ni`=0, `ce_hi_i`=1 and `ce_lo_ni`=0. It loads `addr_i` whatever `ctrl_stb_ni` and the write enables are, writes nothing, and leaves the cycle as a read.
- R3: With `ce_main_ni`=1 the processor strobe is blocked. If `ctrl_stb_ni`=1 on that edge, the edge acts as an ordinary non-strobe edge: the current address and read stay in place and `addr_i` is not loaded.
- R4: A controller start needs `ctrl_stb_ni`=0 and no effective processor strobe on the same edge. If both strobes are in effect, the processor start wins and nothing is written. The write enables are sampled on the controller edge, and `wdata_i` is written to `addr_i` there.
- R5: On a processor start edge, `adv_ni` and the lane write strobes have no effect. The address is not advanced and no lane is written.
- R6: On edges that are not starts, the burst address advances only when `adv_ni`=0 and both strobes are 1. With `adv_ni`=1 the address holds. Any write on that edge goes to the address in effect after the edge.
- R7: With `order_sel_i`=0 the k-th burst address has low bits (start+k) mod 4. The upper address bits stay fixed.
- R8: With `order_sel_i`=1 the k-th burst address has low bits start XOR k.
- R9: `rdata_oe_o` is 1 only while a started cycle is in the read state, `oe_ni`=0 and `sleep_i`=0. It drops in the cycle after any write-sampling edge, whatever `oe_ni` is, and follows `oe_ni` without waiting for a clock.
- R10: A start edge with any chip enable inactive is a deselect. It turns the output off, and later edges neither write nor read until the next valid start.
- R11: `sleep_i`=1 turns the output off at once. Clock edges during sleep load nothing and write nothing, stored words are kept, and after sleep the device is deselected.
- R12: After reset `rdata_oe_o` is 0 and no burst is active.
- R13: Reads are flow-through: `rdata_o` shows the array word at the registered address in the cycle after the edge. This includes a word written at that address on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_main_ni | input | 1 | Master chip enable, active low |
| ce_hi_i | input | 1 | Chip enable, active high |
| ce_lo_ni | input | 1 | Chip enable, active low |
| gw_ni | input | 1 | Global write enable, active low |
| bw_en_ni | input | 1 | Byte-write enable, active low |
| lane_we_ni | input | NUM_LANES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Asynchronous sleep |
| wdata_i | input | NUM_LANES*LANE_W | Write data |
| rdata_o | output | NUM_LANES*LANE_W | Flow-through read data |
| rdata_oe_o | output | 1 | Read data drive enable |

## Verification
The bench builds the block with its defaults: ADDR_W=6, NUM_LANES=2 and LANE_W=9. That gives a 64-word array with 18-bit words. Bursts are placed at bases such as 0x14 and 0x20, so the upper address bits are visibly held fixed. Bursts start at non-zero offsets, which makes the linear wrap and the interleaved XOR pattern give different address sequences. Two lanes are enough to show a partial write that keeps the other lane intact.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic {ORDER_LINEAR = 1'b0, ORDER_INTERLEAVE = 1'b1} burst_order_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       order);
    return (order == ORDER_INTERLEAVE) ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int NUM_LANES = 2
) (
  input  logic                 gw_ni,
  input  logic                 bw_en_ni,
  input  logic [NUM_LANES-1:0] lane_we_ni,
  output logic [NUM_LANES-1:0] lane_wr_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_wr_o[l] = !gw_ni || (!bw_en_ni && !lane_we_ni[l]);
  end

  // R1
  always_comb begin
    if (gw_ni == 1'b0) gw_all_chk: assert (&lane_wr_o);
  end
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  import sram_burst_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q, cnt_q, cnt_inc;

  assign cnt_inc = cnt_q + 2'd1;
  assign addr_o  = {hi_q, burst_offset(start_q, cnt_q, order_i)};

  always_comb begin
    if (load_i)      nxt_addr_o = addr_i;
    else if (step_i) nxt_addr_o = {hi_q, burst_offset(start_q, cnt_inc, order_i)};
    else             nxt_addr_o = addr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      hi_q    <= addr_i[ADDR_W-1:2];
      start_q <= addr_i[1:0];
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_inc;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> (cnt_q == $past(cnt_q)) && $stable(hi_q));
  // R7
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(hi_q));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 9
) (
  input  logic                        clk_i,
  input  logic [NUM_LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [NUM_LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [NUM_LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/flowthru_burst_sram.sv
module flowthru_burst_sram #(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        proc_stb_ni,
  input  logic                        ctrl_stb_ni,
  input  logic                        adv_ni,
  input  logic                        ce_main_ni,
  input  logic                        ce_hi_i,
  input  logic                        ce_lo_ni,
  input  logic                        gw_ni,
  input  logic                        bw_en_ni,
  input  logic [NUM_LANES-1:0]        lane_we_ni,
  input  logic                        oe_ni,
  input  logic                        order_sel_i,
  input  logic                        sleep_i,
  input  logic [NUM_LANES*LANE_W-1:0] wdata_i,
  output logic [NUM_LANES*LANE_W-1:0] rdata_o,
  output logic                        rdata_oe_o
);
  localparam int WORD_W = NUM_LANES * LANE_W;

  logic ce_ok, proc_hit, ctrl_hit, start, start_ok, deselect, cont, step;
  logic active_q, wr_q;
  logic [NUM_LANES-1:0] lane_wr, wr_lanes;
  logic [ADDR_W-1:0]    addr_q, nxt_addr;
  logic [WORD_W-1:0]    arr_rdata;

  assign ce_ok    = !ce_main_ni && ce_hi_i && !ce_lo_ni;
  assign proc_hit = !proc_stb_ni && !ce_main_ni;   // master enable blocks this strobe
  assign ctrl_hit = !ctrl_stb_ni && !proc_hit;
  assign start    = proc_hit || ctrl_hit;
  assign start_ok = start && ce_ok && !sleep_i;
  assign deselect = start && !ce_ok && !sleep_i;
  assign cont     = !start && active_q && !sleep_i;
  assign step     = cont && !adv_ni && proc_stb_ni && ctrl_stb_ni;

  sram_wr_decode #(.NUM_LANES(NUM_LANES)) u_dec (
    .gw_ni      (gw_ni),
    .bw_en_ni   (bw_en_ni),
    .lane_we_ni (lane_we_ni),
    .lane_wr_o  (lane_wr)
  );

  // writes sampled on controller starts and burst continuation only
  assign wr_lanes = ((ctrl_hit && start_ok) || cont) ? lane_wr : '0;

  sram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .step_i     (step),
    .order_i    (order_sel_i),
    .addr_i     (addr_i),
    .addr_o     (addr_q),
    .nxt_addr_o (nxt_addr)
  );

  sram_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (wr_lanes),
    .waddr_i (nxt_addr),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (sleep_i || deselect) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (start_ok || cont) begin
      active_q <= 1'b1;
      wr_q     <= |wr_lanes;
    end
  end

  assign rdata_o    = arr_rdata;
  assign rdata_oe_o = active_q && !wr_q && !oe_ni && !sleep_i;

  // R2
  proc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_hit && ce_ok && !sleep_i) |=> (addr_q == $past(addr_i)));
  // R9
  wr_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_lanes) |=> !rdata_oe_o);
  // R10
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deselect |=> !rdata_oe_o && !active_q);
  // R11
  sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active_q && $stable(addr_q));
  // R5
  proc_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_hit && !sleep_i) |-> (wr_lanes == '0));
endmodule

// File: tb/tb_flowthru_burst_sram.sv
module tb_flowthru_burst_sram;
  localparam int AW = 6;
  localparam int WW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_n, ctrl_n, adv_n, ce_main_n, ce_hi, ce_lo_n, gw_n, bw_n, oe_n, order, sleep;
  logic [1:0] lane_n;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic rdata_oe;

  logic [WW-1:0] model [64];
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  flowthru_burst_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(proc_n), .ctrl_stb_ni(ctrl_n),
    .adv_ni(adv_n), .ce_main_ni(ce_main_n), .ce_hi_i(ce_hi), .ce_lo_ni(ce_lo_n),
    .gw_ni(gw_n), .bw_en_ni(bw_n), .lane_we_ni(lane_n), .oe_ni(oe_n),
    .order_sel_i(order), .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  task automatic idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; lane_n = 2'b11;
  endtask

  task automatic tick();
    @(posedge clk); #2; idle();
  endtask

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_read(input string req, input logic [AW-1:0] a);
    chk({req, " oe"}, {17'b0, rdata_oe}, 18'd1);
    chk({req, " data"}, rdata, model[a]);
  endtask

  task automatic expect_off(input string req);
    chk({req, " oe"}, {17'b0, rdata_oe}, 18'd0);
  endtask

  // controller-start write; model follows R1 lane rules
  task automatic ctrl_write(input logic [AW-1:0] a, input logic [WW-1:0] d,
                            input logic g, input logic b, input logic [1:0] ln);
    ctrl_n = 0; addr = a; wdata = d; gw_n = g; bw_n = b; lane_n = ln;
    for (int l = 0; l < 2; l++)
      if (!g || (!b && !ln[l])) model[a][l*9 +: 9] = d[l*9 +: 9];
    tick();
  endtask

  task automatic proc_start(input logic [AW-1:0] a);
    proc_n = 0; addr = a; tick();
  endtask

  task automatic adv_step();
    adv_n = 0; tick();
  endtask

  task automatic t_reset();
    expect_off("R12 reset");
  endtask

  task automatic t_write_read();
    ctrl_write(6'h08, 18'h2_A5C3, 0, 1, 2'b11);
    expect_off("R9 after ctrl write");
    proc_start(6'h08);
    expect_read("R4/R13 full write readback", 6'h08);
    ctrl_write(6'h08, 18'h1_1111, 1, 0, 2'b10);   // lane0 only
    proc_start(6'h08);
    expect_read("R1 lane0 write keeps lane1", 6'h08);
    ctrl_write(6'h08, 18'h3_FFFF, 1, 1, 2'b00);   // bw disabled: read
    expect_read("R1 no-enable is read", 6'h08);
  endtask

  task automatic t_strobe_rules();
    ctrl_write(6'h30, 18'h0_0030, 0, 1, 2'b11);
    ctrl_write(6'h31, 18'h0_0031, 0, 1, 2'b11);
    // both strobes low, write enables low: processor start wins
    proc_n = 0; ctrl_n = 0; addr = 6'h30; gw_n = 0; wdata = 18'h3_BEEF; tick();
    expect_read("R4 processor wins, no write", 6'h30);
    // R5: advance and lane strobes on processor edge ignored
    proc_n = 0; addr = 6'h31; adv_n = 0; bw_n = 0; lane_n = 2'b00; wdata = 18'h2_2222; tick();
    expect_read("R5 no advance no write", 6'h31);
    // R3: blocked processor strobe, controller high -> no load
    ce_main_n = 1; proc_n = 0; addr = 6'h08; tick(); ce_main_n = 0;
    expect_read("R3 blocked strobe keeps address", 6'h31);
    // R3/R10: blocked processor strobe with controller low -> deselect
    ce_main_n = 1; proc_n = 0; ctrl_n = 0; addr = 6'h08; tick(); ce_main_n = 0;
    expect_off("R3 controller edge with master off");
  endtask

  task automatic t_bursts();
    for (int i = 0; i < 4; i++) ctrl_write(6'h14 + i[5:0], 18'h1_0000 + i, 0, 1, 2'b11);
    order = 0;
    proc_start(6'h16);
    expect_read("R7 linear k0", 6'h16);
    adv_step(); expect_read("R7 linear k1", 6'h17);
    adv_step(); expect_read("R7 linear wrap k2", 6'h14);
    adv_step(); expect_read("R7 linear k3", 6'h15);
    order = 1;
    proc_start(6'h15);
    adv_step(); expect_read("R8 interleave k1", 6'h14);
    adv_step(); expect_read("R8 interleave k2", 6'h17);
    adv_step(); expect_read("R8 interleave k3", 6'h16);
    tick();     expect_read("R6 adv high holds", 6'h16);
    // advance with a strobe low is a new start, not a step
    proc_n = 0; addr = 6'h14; adv_n = 0; tick();
    expect_read("R6 strobe edge loads not steps", 6'h14);
  endtask

  task automatic t_burst_write();
    order = 0;
    proc_start(6'h20);
    gw_n = 0; wdata = 18'h0_AAAA; model[6'h20] = 18'h0_AAAA; tick();
    expect_off("R9 suspend write blanks output");
    gw_n = 0; adv_n = 0; wdata = 18'h0_BBBB; model[6'h21] = 18'h0_BBBB; tick();
    tick();
    expect_read("R6/R13 advanced write at next address", 6'h21);
    oe_n = 1; #1;
    expect_off("R9 oe high async");
    oe_n = 0; #1;
    proc_start(6'h20);
    expect_read("R13 suspended write readback", 6'h20);
  endtask

  task automatic t_deselect();
    proc_start(6'h30);
    ce_hi = 0; proc_n = 0; addr = 6'h31; tick(); ce_hi = 1;
    expect_off("R10 deselect output off");
    adv_n = 0; gw_n = 0; wdata = 18'h3_DEAD; tick();
    expect_off("R10 no activity after deselect");
    proc_start(6'h30); expect_read("R10 word A kept", 6'h30);
    proc_start(6'h31); expect_read("R10 word B kept", 6'h31);
  endtask

  task automatic t_sleep();
    proc_start(6'h14);
    sleep = 1; #1;
    expect_off("R11 sleep async off");
    ctrl_n = 0; addr = 6'h14; gw_n = 0; wdata = 18'h0_5555; tick();
    sleep = 0; #1;
    expect_off("R11 deselected after sleep");
    proc_start(6'h14);
    expect_read("R11 contents kept", 6'h14);
  endtask

  initial begin
    ce_main_n = 0; ce_hi = 1; ce_lo_n = 0; oe_n = 0; order = 1; sleep = 0;
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1 t_reset();
    t_write_read();
    t_strobe_rules();
    t_bursts();
    t_burst_write();
    t_deselect();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule